// File: doc/BRIEF.md
# Flip-Flop Transpose Buffer for Separable 2-D Transforms

This block sits between the row stage and the column stage of a separable two-dimensional transform. It receives one square block of N×N samples as a serial stream in row order. It returns the same block as a serial stream in column order. All storage is a regular array of D flip-flops. There is no RAM and no address generator.

Each cell has a two-input selector. In one mode the cells form a single shift chain in row-major order. In the other mode they form a chain in column-major order. The mode toggles after every N×N accepted samples. The block being read out leaves the array in the same shift step that takes in each sample of the next block, so one array carries two blocks at once and the stream needs no gap between blocks.

Both streams use valid/ready handshakes. A sample enters when `in_valid` and `in_ready` are both high at a rising clock edge. Once the array holds a full block, every accepted input pushes one output, so:
- `out_valid` follows `in_valid`.
- `in_ready` follows `out_ready`.

Neither signal depends combinationally on itself. The last block of a stream stays in the array until the next block pushes it out.

Top module: `tpb_transpose`

## Requirements
- R1: While reset is applied, and right after it, the buffer is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: During the first N×N accepted samples after reset, `in_ready` is 1 whatever `out_ready` is, and `out_valid` stays 0.
- R3: Let k (from 0) be the position of an output sample within its output block. It equals input sample number (k mod N)·N + ⌊k/N⌋ of the matching input block, where input samples are numbered from 0 in arrival order.
- R4: Once a full block is held, `out_valid` equals `in_valid`. Output block b appears one sample per accepted input of block b+1, with no extra latency and no gaps between blocks.
- R5: When `in_valid` is 0, `out_valid` is 0 and the array contents do not change. Data accepted afterwards still comes out correctly transposed.
- R6: When a full block is held and `out_ready` is 0, `in_ready` is 0. No sample is accepted, none is lost and none is repeated.
- R7: `out_first` is 1 exactly on the output beat that carries sample 0 of an output block, and is 0 whenever `out_valid` is 0.
- R8: The shift mode changes after every N×N accepted samples. Blocks written in row-major mode and blocks written in column-major mode are both read out transposed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Buffer can accept the input sample this cycle |
| in_data | input | W | Input sample, row order |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | W | Output sample, column order |
| out_first | output | 1 | Marks sample 0 of each output block |

## Verification
The bench builds the buffer with N = 8 and W = 16. At these values the full chain is 64 deep, and patterns whose strides are coprime to 2^16 give every sample of a block a distinct value. A wrong permutation, a lost sample or a repeated sample therefore always shows as a data mismatch. Six or more consecutive blocks pass through both shift modes several times. Input gaps and output stalls fall at positions inside a block, on its first sample and on its last sample. Resets in the middle of a block bring the empty-buffer and first-block behaviour back within reach.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef enum logic {
    TPB_ROWMAJ = 1'b0,
    TPB_COLMAJ = 1'b1
  } tpb_mode_e;

  // Source of a cell when the chain runs in row-major order.
  // A return value of n*n stands for the serial input.
  function automatic int row_src(input int idx, input int n);
    return idx + 1;
  endfunction

  // Source of a cell when the chain runs in column-major order.
  function automatic int col_src(input int idx, input int n);
    int r;
    int c;
    int j;
    r = idx / n;
    c = idx % n;
    j = c * n + r + 1;
    if (j >= n * n) return n * n;
    return (j % n) * n + (j / n);
  endfunction

endpackage

// File: rtl/tpb_cell.sv
module tpb_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sel,
  input  logic [W-1:0] d_row,
  input  logic [W-1:0] d_col,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= sel ? d_col : d_row;
    end
  end

endmodule

// File: rtl/tpb_array.sv
module tpb_array #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int NN = N * N;

  logic [W-1:0] cellq [NN];

  for (genvar i = 0; i < NN; i++) begin : g_cell
    localparam int RS = tpb_pkg::row_src(i, N);
    localparam int CS = tpb_pkg::col_src(i, N);
    logic [W-1:0] d_r;
    logic [W-1:0] d_c;

    if (RS >= NN) begin : g_rin
      assign d_r = din;
    end else begin : g_rcell
      assign d_r = cellq[RS];
    end

    if (CS >= NN) begin : g_cin
      assign d_c = din;
    end else begin : g_ccell
      assign d_c = cellq[CS];
    end

    tpb_cell #(.W(W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (shift),
      .sel  (mode),
      .d_row(d_r),
      .d_col(d_c),
      .q    (cellq[i])
    );
  end

  assign dout = cellq[0];

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(cellq[0]));

  // R5
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(cellq[NN-1]));

endmodule

// File: rtl/tpb_ctrl.sv
module tpb_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_first,
  output logic shift,
  output logic mode
);

  localparam int NN = N * N;
  localparam int CW = (NN > 1) ? $clog2(NN) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(NN - 1);

  logic [CW-1:0] cnt;
  logic          filled;

  assign in_ready  = !filled || out_ready;
  assign shift     = in_valid && in_ready;
  assign out_valid = filled && in_valid;
  assign out_first = out_valid && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      filled <= 1'b0;
      mode   <= tpb_pkg::TPB_ROWMAJ;
    end else if (shift) begin
      if (cnt == LAST_C) begin
        cnt    <= '0;
        filled <= 1'b1;
        mode   <= ~mode;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  mode_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && cnt == LAST_C) |=> (mode != $past(mode)));

  // R8
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && cnt == LAST_C) |=> $stable(mode));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(cnt));

  // R2
  filled_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled);

endmodule

// File: rtl/tpb_transpose.sv
module tpb_transpose #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_first
);

  logic shift;
  logic mode;

  tpb_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_first(out_first),
    .shift    (shift),
    .mode     (mode)
  );

  tpb_array #(.N(N), .W(W)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .shift(shift),
    .mode (mode),
    .din  (in_data),
    .dout (out_data)
  );

  // R6
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  // R7
  first_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (in_ready || !rst_n));

endmodule

// File: tb/tb_tpb_transpose.sv
module tb_tpb_transpose;

  localparam int N    = 8;
  localparam int W    = 16;
  localparam int NN   = N * N;
  localparam int NVEC = 6;

  // base, stride, input gap period, output stall period
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0000, 16'h0001, 4'd0, 4'd0},
    {16'h8000, 16'h0101, 4'd0, 4'd0},
    {16'hFFFF, 16'hFFFF, 4'd3, 4'd0},
    {16'h1234, 16'h0007, 4'd0, 4'd4},
    {16'hA5A5, 16'h0F0F, 4'd5, 4'd3},
    {16'h0042, 16'h0100, 4'd0, 4'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         out_first;

  int checks = 0;
  int fails  = 0;
  int acc_total, iidx, iblk, oidx, oblk;
  logic [W-1:0] ref_mem [8*NN];

  always #5 clk = ~clk;

  tpb_transpose #(.N(N), .W(W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_first(out_first)
  );

  function automatic logic [W-1:0] pat(input int b, input int i);
    if (b < NVEC) return VEC[b][39:24] + VEC[b][23:8] * W'(i);
    return W'(16'h3C00 + b * 16'h0040 + i * 3);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    acc_total = 0; iidx = 0; iblk = 0; oidx = 0; oblk = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic rdy);
    logic exp_ir;
    logic exp_ov;
    int   src;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = rdy;
    #2;
    exp_ir = rdy || (acc_total < NN);
    exp_ov = v && (acc_total >= NN);
    if (acc_total < NN) begin
      check(in_ready == exp_ir, "R2 in_ready", in_ready, exp_ir);
      check(out_valid == exp_ov, "R2 out_valid", out_valid, exp_ov);
    end else begin
      check(in_ready == exp_ir, "R6 in_ready", in_ready, exp_ir);
      if (v) check(out_valid == exp_ov, "R4 out_valid", out_valid, exp_ov);
      else   check(out_valid == exp_ov, "R5 out_valid", out_valid, exp_ov);
    end
    if (!out_valid) check(out_first == 1'b0, "R7 out_first idle", out_first, 0);
    if (out_valid && out_ready) begin
      src = (oidx % N) * N + (oidx / N);
      check(out_data == ref_mem[(oblk % 8) * NN + src], "R3 out_data",
            out_data, ref_mem[(oblk % 8) * NN + src]);
      check(out_first == (oidx == 0), "R7 out_first", out_first, (oidx == 0));
      oidx++;
      if (oidx == NN) begin oidx = 0; oblk++; end
    end
    if (v && in_ready) begin
      ref_mem[(iblk % 8) * NN + iidx] = d;
      acc_total++;
      iidx++;
      if (iidx == NN) begin iidx = 0; iblk++; end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
    finish_run();
  end

  initial begin
    int b;
    clear_model();
    do_reset();
    // R1: empty after reset, ready even with downstream stalled
    step(1'b0, '0, 1'b0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // table walk: consecutive blocks in alternating modes (R3, R4, R8)
    for (int v = 0; v < NVEC; v++) begin
      int s = 0;
      int gap = int'(VEC[v][7:4]);
      int stl = int'(VEC[v][3:0]);
      while (iblk == v) begin
        logic vv = !(gap != 0 && (s % gap) == gap - 1);
        logic rr = !(stl != 0 && (s % stl) == stl - 1);
        step(vv, pat(v, iidx), rr);
        s++;
      end
    end
    check(oblk == NVEC - 1, "R8 blocks drained", oblk, NVEC - 1);

    // R5: idle input holds the array
    for (int k = 0; k < 5; k++) step(1'b0, 16'hDEAD, 1'b1);
    // R6: stall on the first sample of the next block
    for (int k = 0; k < 4; k++) step(1'b1, pat(NVEC, iidx), 1'b0);
    check(acc_total == NVEC * NN, "R6 nothing accepted", acc_total, NVEC * NN);
    b = NVEC;
    while (iblk == b) begin
      if (iidx == NN - 1) step(1'b1, pat(b, iidx), 1'b0);
      step(1'b1, pat(b, iidx), 1'b1);
    end
    check(oblk == NVEC, "R4 block pushed out", oblk, NVEC);

    // R1: reset in the middle of a block
    for (int k = 0; k < 10; k++) step(1'b1, pat(b + 1, iidx), 1'b1);
    do_reset();
    step(1'b1, pat(0, 0), 1'b0);
    check(out_valid == 1'b0, "R1 out_valid after mid reset", out_valid, 0);
    // R2: first block accepted with downstream stalled
    while (acc_total < NN) step(1'b1, pat(2, iidx), 1'b0);
    step(1'b1, pat(3, iidx), 1'b0);
    check(in_ready == 1'b0, "R6 full and stalled", in_ready, 0);
    check(out_valid == 1'b1, "R4 full output valid", out_valid, 1);
    // release and stream one more block to verify content kept (R3)
    while (iblk == 1 || acc_total < 2 * NN) step(1'b1, pat(3, iidx), 1'b1);
    check(oblk == 1, "R3 post-reset block out", oblk, 1);
    finish_run();
  end

endmodule